// File: doc/BRIEF.md
# Segmented Receive Packet Realigner

This block sits behind a wide receive interface that delivers each clock cycle as four parallel segments. Every segment carries its own data word, a 128-bit header, a 32-bit prefix dword, separate qualifiers for data, header and prefix, start and end markers, an empty-dword count and a set of routing fields (target BAR, physical function, VF-active flag, VF number). Several packets may begin and end within one cycle, and one packet may span segments and cycles. The block walks the segments from the lowest index to the highest and carries an open packet from segment 3 into segment 0 of the next cycle. It turns the traffic into one ordered stream of segment-sized beats, marked with start, end and a per-dword enable.

The source cannot be stalled, so every valid segment is taken in the cycle it arrives. Accepted segments go into a small multi-write FIFO that drains one beat per cycle. Overflow, framing mistakes, too many start markers and parity mismatches each raise a one-cycle error flag.

Top module: `segrx_realign`

## Requirements
- R1: After reset, and with no traffic, `out_valid` and all four error flags are low.
- R2: Segments accepted in one cycle are written to the FIFO at that clock edge and leave one per cycle in ascending segment order. The first beat is valid after the second rising edge counted from the edge that sampled the input. Each packet shows exactly one start beat and one end beat, in that order.
- R3: A packet left open at segment 3 continues in segment 0 of the next cycle without any error. Only its first beat carries `out_sop`, and only its last beat carries `out_eop`.
- R4: On an end beat, dword i of `out_data` is enabled if and only if i < DATA_W/32 minus the empty count. A beat that is not an end beat has every dword enabled, and the empty field of a non-end segment has no effect.
- R5: On a start beat, header, BAR, physical function number and VF-active flag come from the start segment. `out_vfnum` equals the input VF number when the VF-active flag is set and is zero otherwise.
- R6: A start segment with its prefix qualifier high passes its prefix dword. With the qualifier low, the prefix reads as zero. `out_has_prefix` is high exactly when the passed prefix dword is nonzero.
- R7: Each 32-bit group of data, header or prefix has one parity bit equal to the XOR of its bits. A mismatch on a field whose qualifier is high pulses `err_parity` one cycle after the input. Mismatches on fields whose qualifier is low are ignored.
- R8: A data-valid segment that arrives while no packet is open and carries no start marker is dropped and pulses `err_frame`. The same applies to a start marker that arrives while a packet is open, in which case the open packet stays open.
- R9: More than three start markers on data-valid segments in one cycle pulse `err_sop_excess` one cycle later.
- R10: Free FIFO space is the depth minus the occupancy before that edge's read. Accepted segments beyond the free space are dropped in segment order and pulse `err_overflow`. With depth 8, three cycles of four single-segment packets yield nine output beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | NSEG*DATA_W | Data word per segment |
| in_hdr | input | NSEG*128 | Header per segment |
| in_prefix | input | NSEG*32 | Prefix dword per segment |
| in_dvalid | input | NSEG | Data qualifier per segment |
| in_hvalid | input | NSEG | Header qualifier per segment |
| in_pvalid | input | NSEG | Prefix qualifier per segment |
| in_sop | input | NSEG | Start marker per segment |
| in_eop | input | NSEG | End marker per segment |
| in_empty | input | NSEG*3 | Empty dwords at the top of the end segment |
| in_bar | input | NSEG*3 | Target BAR per segment |
| in_pfnum | input | NSEG*3 | Physical function number per segment |
| in_vfactive | input | NSEG | VF-active flag per segment |
| in_vfnum | input | NSEG*11 | VF number per segment |
| in_data_par | input | NSEG*DATA_W/32 | Data parity, one bit per dword |
| in_hdr_par | input | NSEG*4 | Header parity, one bit per dword |
| in_prefix_par | input | NSEG | Prefix parity |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Beat starts a packet |
| out_eop | output | 1 | Beat ends a packet |
| out_data | output | DATA_W | Beat data |
| out_dw_en | output | DATA_W/32 | Per-dword enable |
| out_hdr | output | 128 | Header (start beats) |
| out_prefix | output | 32 | Prefix dword (start beats) |
| out_has_prefix | output | 1 | Prefix dword is nonzero |
| out_bar | output | 3 | Target BAR (start beats) |
| out_pfnum | output | 3 | Physical function (start beats) |
| out_vf_active | output | 1 | Targets a virtual function |
| out_vfnum | output | 11 | VF number, zero unless VF-active |
| err_parity | output | 1 | Parity mismatch pulse |
| err_frame | output | 1 | Framing error pulse |
| err_sop_excess | output | 1 | Too many start markers pulse |
| err_overflow | output | 1 | FIFO overflow pulse |

## Verification
The hardest state to reach is a FIFO that is full enough to cut a cycle's writes in the middle. The output drains one beat per cycle and gives no back-pressure, so the only way in is a run of cycles with all four segments loaded. The stimulus sends three consecutive cycles of four single-segment packets and counts the beats that come out. The other hard case is a packet held open across the segment-3 to segment-0 wrap while the next cycle's segment 0 carries a stray empty value. A two-cycle directed sequence builds that case.

// File: rtl/rx_rlgn_pkg.sv
package rx_rlgn_pkg;
   localparam int HDR_W   = 128;
   localparam int PFX_W   = 32;
   localparam int GRP_W   = 32;
   localparam int EMPTY_W = 3;
   localparam int BAR_W   = 3;
   localparam int PF_W    = 3;
   localparam int VF_W    = 11;

   typedef struct packed {
      logic               sop;
      logic               eop;
      logic [EMPTY_W-1:0] empty;
      logic [BAR_W-1:0]   bar;
      logic [PF_W-1:0]    pfnum;
      logic               vf_active;
      logic [VF_W-1:0]    vfnum;
   } seg_meta_t;
endpackage

// File: rtl/rx_rlgn_parity.sv
module rx_rlgn_parity
   import rx_rlgn_pkg::*;
#(
   parameter int NSEG   = 4,
   parameter int DATA_W = 256
) (
   input  logic [NSEG*DATA_W-1:0]         data,
   input  logic [NSEG*HDR_W-1:0]          hdr,
   input  logic [NSEG*PFX_W-1:0]          pfx,
   input  logic [NSEG*(DATA_W/GRP_W)-1:0] dpar,
   input  logic [NSEG*(HDR_W/GRP_W)-1:0]  hpar,
   input  logic [NSEG-1:0]                ppar,
   input  logic [NSEG-1:0]                dvalid,
   input  logic [NSEG-1:0]                hvalid,
   input  logic [NSEG-1:0]                pvalid,
   output logic                           bad
);
   localparam int DG = DATA_W / GRP_W;
   localparam int HG = HDR_W / GRP_W;

   logic [NSEG-1:0] seg_bad;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic bad_s;
      always_comb begin
         bad_s = 1'b0;
         for (int j = 0; j < DG; j++)
            if (dvalid[s] && ((^data[s*DATA_W + j*GRP_W +: GRP_W]) != dpar[s*DG + j]))
               bad_s = 1'b1;
         for (int j = 0; j < HG; j++)
            if (hvalid[s] && ((^hdr[s*HDR_W + j*GRP_W +: GRP_W]) != hpar[s*HG + j]))
               bad_s = 1'b1;
         if (pvalid[s] && ((^pfx[s*PFX_W +: PFX_W]) != ppar[s]))
            bad_s = 1'b1;
      end
      assign seg_bad[s] = bad_s;
   end

   assign bad = |seg_bad;
endmodule

// File: rtl/rx_rlgn_walker.sv
module rx_rlgn_walker #(
   parameter int NSEG    = 4,
   parameter int MAX_SOP = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSEG-1:0] dvalid,
   input  logic [NSEG-1:0] sop,
   input  logic [NSEG-1:0] eop,
   output logic [NSEG-1:0] accept,
   output logic            frame_bad,
   output logic            sop_over
);
   localparam int CNT_W = $clog2(NSEG + 1);

   logic             open_q;
   logic             open_d;
   logic [CNT_W-1:0] sop_cnt;

   always_comb begin
      open_d    = open_q;
      accept    = '0;
      frame_bad = 1'b0;
      for (int s = 0; s < NSEG; s++) begin
         if (dvalid[s]) begin
            if (sop[s] == open_d) begin
               frame_bad = 1'b1;
            end else begin
               accept[s] = 1'b1;
               open_d    = !eop[s];
            end
         end
      end
   end

   always_comb begin
      sop_cnt = '0;
      for (int s = 0; s < NSEG; s++)
         sop_cnt = sop_cnt + CNT_W'(sop[s] & dvalid[s]);
   end
   assign sop_over = (sop_cnt > CNT_W'(MAX_SOP));

   always_ff @(posedge clk) begin
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= open_d;
   end
endmodule

// File: rtl/rx_rlgn_fifo.sv
module rx_rlgn_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   parameter int NWR   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NWR-1:0]   wr_en,
   input  logic [NWR*W-1:0] wr_data,
   input  logic             pop,
   output logic             not_empty,
   output logic [W-1:0]     head,
   output logic             overflow
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("rx_rlgn_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count, free, slot;
   logic [NWR-1:0] wr_ok;
   logic [AW-1:0] wr_idx [NWR];
   logic          do_pop;

   assign free   = CW'(DEPTH) - count;
   assign do_pop = pop && (count != '0);

   always_comb begin
      slot     = '0;
      overflow = 1'b0;
      wr_ok    = '0;
      for (int i = 0; i < NWR; i++) begin
         wr_idx[i] = wr_ptr + AW'(slot);
         if (wr_en[i]) begin
            if (slot < free) begin
               wr_ok[i] = 1'b1;
               slot     = slot + 1'b1;
            end else begin
               overflow = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NWR; i++)
         if (wr_ok[i]) mem[wr_idx[i]] <= wr_data[i*W +: W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(slot);
         rd_ptr <= rd_ptr + AW'(do_pop);
         count  <= count + slot - CW'(do_pop);
      end
   end

   assign not_empty = (count != '0);
   assign head      = mem[rd_ptr];
endmodule

// File: rtl/segrx_realign.sv
module segrx_realign
   import rx_rlgn_pkg::*;
#(
   parameter int NSEG       = 4,
   parameter int DATA_W     = 256,
   parameter int FIFO_DEPTH = 8,
   parameter int MAX_SOP    = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NSEG*DATA_W-1:0]         in_data,
   input  logic [NSEG*128-1:0]            in_hdr,
   input  logic [NSEG*32-1:0]             in_prefix,
   input  logic [NSEG-1:0]                in_dvalid,
   input  logic [NSEG-1:0]                in_hvalid,
   input  logic [NSEG-1:0]                in_pvalid,
   input  logic [NSEG-1:0]                in_sop,
   input  logic [NSEG-1:0]                in_eop,
   input  logic [NSEG*3-1:0]              in_empty,
   input  logic [NSEG*3-1:0]              in_bar,
   input  logic [NSEG*3-1:0]              in_pfnum,
   input  logic [NSEG-1:0]                in_vfactive,
   input  logic [NSEG*11-1:0]             in_vfnum,
   input  logic [NSEG*(DATA_W/32)-1:0]    in_data_par,
   input  logic [NSEG*4-1:0]              in_hdr_par,
   input  logic [NSEG-1:0]                in_prefix_par,
   output logic                           out_valid,
   output logic                           out_sop,
   output logic                           out_eop,
   output logic [DATA_W-1:0]              out_data,
   output logic [DATA_W/32-1:0]           out_dw_en,
   output logic [127:0]                   out_hdr,
   output logic [31:0]                    out_prefix,
   output logic                           out_has_prefix,
   output logic [2:0]                     out_bar,
   output logic [2:0]                     out_pfnum,
   output logic                           out_vf_active,
   output logic [10:0]                    out_vfnum,
   output logic                           err_parity,
   output logic                           err_frame,
   output logic                           err_sop_excess,
   output logic                           err_overflow
);
   localparam int DWORDS = DATA_W / GRP_W;
   localparam int META_W = $bits(seg_meta_t);
   localparam int ITEM_W = META_W + DATA_W + HDR_W + PFX_W;

   if (DATA_W % GRP_W != 0 || DWORDS < 1 || DWORDS > 8) begin : g_bad_width
      $error("segrx_realign: DATA_W must be 32..256 in steps of 32");
   end
   if (MAX_SOP < 1 || MAX_SOP > NSEG) begin : g_bad_sop
      $error("segrx_realign: MAX_SOP must lie in 1..NSEG");
   end

   logic [NSEG-1:0]        accept;
   logic                   frame_bad, sop_over, par_bad, fifo_ovf, fifo_ne;
   logic [NSEG*ITEM_W-1:0] wr_data;
   logic [ITEM_W-1:0]      head;
   seg_meta_t              h_meta;
   logic [DATA_W-1:0]      h_data;
   logic [HDR_W-1:0]       h_hdr;
   logic [PFX_W-1:0]       h_pfx;
   logic [DWORDS-1:0]      dw_en;

   rx_rlgn_walker #(.NSEG(NSEG), .MAX_SOP(MAX_SOP)) u_walk (
      .clk(clk), .rst_n(rst_n), .dvalid(in_dvalid), .sop(in_sop), .eop(in_eop),
      .accept(accept), .frame_bad(frame_bad), .sop_over(sop_over)
   );

   rx_rlgn_parity #(.NSEG(NSEG), .DATA_W(DATA_W)) u_par (
      .data(in_data), .hdr(in_hdr), .pfx(in_prefix),
      .dpar(in_data_par), .hpar(in_hdr_par), .ppar(in_prefix_par),
      .dvalid(in_dvalid), .hvalid(in_hvalid), .pvalid(in_pvalid), .bad(par_bad)
   );

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      seg_meta_t        m;
      logic [HDR_W-1:0] hdr_s;
      logic [PFX_W-1:0] pfx_s;
      always_comb begin
         m       = '0;
         m.sop   = in_sop[s];
         m.eop   = in_eop[s];
         m.empty = in_eop[s] ? in_empty[s*EMPTY_W +: EMPTY_W] : '0;
         if (in_sop[s]) begin
            m.bar       = in_bar[s*BAR_W +: BAR_W];
            m.pfnum     = in_pfnum[s*PF_W +: PF_W];
            m.vf_active = in_vfactive[s];
            m.vfnum     = in_vfactive[s] ? in_vfnum[s*VF_W +: VF_W] : '0;
         end
         hdr_s = (in_sop[s] && in_hvalid[s]) ? in_hdr[s*HDR_W +: HDR_W]    : '0;
         pfx_s = (in_sop[s] && in_pvalid[s]) ? in_prefix[s*PFX_W +: PFX_W] : '0;
      end
      assign wr_data[s*ITEM_W +: ITEM_W] = {m, in_data[s*DATA_W +: DATA_W], hdr_s, pfx_s};
   end

   rx_rlgn_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH), .NWR(NSEG)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(wr_data),
      .pop(fifo_ne), .not_empty(fifo_ne), .head(head), .overflow(fifo_ovf)
   );

   assign {h_meta, h_data, h_hdr, h_pfx} = head;

   always_comb begin
      for (int i = 0; i < DWORDS; i++)
         dw_en[i] = !h_meta.eop || (i < DWORDS - int'(h_meta.empty));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_sop        <= 1'b0;
         out_eop        <= 1'b0;
         out_data       <= '0;
         out_dw_en      <= '0;
         out_hdr        <= '0;
         out_prefix     <= '0;
         out_has_prefix <= 1'b0;
         out_bar        <= '0;
         out_pfnum      <= '0;
         out_vf_active  <= 1'b0;
         out_vfnum      <= '0;
         err_parity     <= 1'b0;
         err_frame      <= 1'b0;
         err_sop_excess <= 1'b0;
         err_overflow   <= 1'b0;
      end else begin
         out_valid      <= fifo_ne;
         out_sop        <= fifo_ne && h_meta.sop;
         out_eop        <= fifo_ne && h_meta.eop;
         out_data       <= h_data;
         out_dw_en      <= dw_en;
         out_hdr        <= h_hdr;
         out_prefix     <= h_pfx;
         out_has_prefix <= fifo_ne && (h_pfx != '0);
         out_bar        <= h_meta.bar;
         out_pfnum      <= h_meta.pfnum;
         out_vf_active  <= fifo_ne && h_meta.vf_active;
         out_vfnum      <= h_meta.vfnum;
         err_parity     <= par_bad;
         err_frame      <= frame_bad;
         err_sop_excess <= sop_over;
         err_overflow   <= fifo_ovf;
      end
   end
endmodule

// File: rtl/segrx_realign_chk.sv
module segrx_realign_chk #(
   parameter int NSEG   = 4,
   parameter int DWORDS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSEG-1:0]   in_dvalid,
   input logic [NSEG-1:0]   in_sop,
   input logic              out_valid,
   input logic              out_sop,
   input logic              out_eop,
   input logic [DWORDS-1:0] out_dw_en,
   input logic              out_vf_active,
   input logic [10:0]       out_vfnum,
   input logic              out_has_prefix,
   input logic [31:0]       out_prefix,
   input logic              err_frame,
   input logic              err_sop_excess,
   input logic              err_overflow
);
   logic chk_open, ovf_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_open <= 1'b0;
         ovf_seen <= 1'b0;
      end else begin
         if (err_overflow) ovf_seen <= 1'b1;
         if (out_valid) chk_open <= out_sop ? !out_eop : (chk_open && !out_eop);
      end
   end

   AST_NO_NESTED_SOP: assert property (@(posedge clk) disable iff (!rst_n || ovf_seen)
      out_valid && out_sop |-> !chk_open);                                 // R2
   AST_CONT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n || ovf_seen)
      out_valid && !out_sop |-> chk_open);                                 // R3
   AST_MID_FULL_DWEN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_eop |-> &out_dw_en);                               // R4
   AST_DWEN_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((({1'b0, out_dw_en}) + 1'b1) & {1'b0, out_dw_en}) == '0); // R4
   AST_VFNUM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_vf_active |-> out_vfnum == '0);                    // R5
   AST_PFX_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_has_prefix |-> out_prefix == '0);                  // R6
   AST_FRAME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_frame) |-> $past(|in_dvalid));                             // R8
   AST_SOP_EXCESS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sop_excess) |-> $past($countones(in_sop & in_dvalid) > 3)); // R9
   AST_NO_OVERFLOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overflow) |-> $past(|in_dvalid));                          // R10
endmodule

bind segrx_realign segrx_realign_chk #(.NSEG(NSEG), .DWORDS(DATA_W/32)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_dvalid(in_dvalid), .in_sop(in_sop),
   .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_dw_en(out_dw_en),
   .out_vf_active(out_vf_active), .out_vfnum(out_vfnum),
   .out_has_prefix(out_has_prefix), .out_prefix(out_prefix),
   .err_frame(err_frame), .err_sop_excess(err_sop_excess), .err_overflow(err_overflow)
);

// File: tb/segrx_realign_tb.sv
module segrx_realign_tb;
   localparam int NSEG = 4;
   localparam int DW   = 256;
   localparam int NDW  = DW / 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NSEG*DW-1:0]  in_data;
   logic [NSEG*128-1:0] in_hdr;
   logic [NSEG*32-1:0]  in_prefix;
   logic [NSEG-1:0]     in_dvalid, in_hvalid, in_pvalid, in_sop, in_eop, in_vfactive;
   logic [NSEG*3-1:0]   in_empty, in_bar, in_pfnum;
   logic [NSEG*11-1:0]  in_vfnum;
   logic [NSEG*NDW-1:0] in_data_par, cor_d;
   logic [NSEG*4-1:0]   in_hdr_par, cor_h;
   logic [NSEG-1:0]     in_prefix_par, cor_p;

   logic            out_valid, out_sop, out_eop, out_has_prefix, out_vf_active;
   logic [DW-1:0]   out_data;
   logic [NDW-1:0]  out_dw_en;
   logic [127:0]    out_hdr;
   logic [31:0]     out_prefix;
   logic [2:0]      out_bar, out_pfnum;
   logic [10:0]     out_vfnum;
   logic            err_parity, err_frame, err_sop_excess, err_overflow;

   segrx_realign u_dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_hdr(in_hdr), .in_prefix(in_prefix),
      .in_dvalid(in_dvalid), .in_hvalid(in_hvalid), .in_pvalid(in_pvalid),
      .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_bar(in_bar),
      .in_pfnum(in_pfnum), .in_vfactive(in_vfactive), .in_vfnum(in_vfnum),
      .in_data_par(in_data_par), .in_hdr_par(in_hdr_par), .in_prefix_par(in_prefix_par),
      .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
      .out_dw_en(out_dw_en), .out_hdr(out_hdr), .out_prefix(out_prefix),
      .out_has_prefix(out_has_prefix), .out_bar(out_bar), .out_pfnum(out_pfnum),
      .out_vf_active(out_vf_active), .out_vfnum(out_vfnum), .err_parity(err_parity),
      .err_frame(err_frame), .err_sop_excess(err_sop_excess), .err_overflow(err_overflow)
   );

   always_comb begin
      for (int s = 0; s < NSEG; s++) begin
         for (int j = 0; j < NDW; j++)
            in_data_par[s*NDW+j] = (^in_data[s*DW + 32*j +: 32]) ^ cor_d[s*NDW+j];
         for (int j = 0; j < 4; j++)
            in_hdr_par[s*4+j] = (^in_hdr[s*128 + 32*j +: 32]) ^ cor_h[s*4+j];
         in_prefix_par[s] = (^in_prefix[s*32 +: 32]) ^ cor_p[s];
      end
   end

   int total = 0, bad = 0, cap_n = 0;
   bit done = 0;
   logic [7:0]     cap_tag [32];
   logic           cap_sop [32], cap_eop [32], cap_hp [32];
   logic [NDW-1:0] cap_dwen [32];
   logic [31:0]    cap_pfx [32];
   logic [127:0]   s_hdr;
   logic [2:0]     s_bar, s_pf;
   logic           s_vfa;
   logic [10:0]    s_vfn;
   bit seen_par, seen_frm, seen_sopx, seen_ovf;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && cap_n < 32) begin
            cap_tag[cap_n]  = out_data[7:0];
            cap_sop[cap_n]  = out_sop;
            cap_eop[cap_n]  = out_eop;
            cap_dwen[cap_n] = out_dw_en;
            cap_pfx[cap_n]  = out_prefix;
            cap_hp[cap_n]   = out_has_prefix;
            if (out_sop) begin
               s_hdr = out_hdr; s_bar = out_bar; s_pf = out_pfnum;
               s_vfa = out_vf_active; s_vfn = out_vfnum;
            end
            cap_n++;
         end
         if (err_parity)     seen_par  = 1;
         if (err_frame)      seen_frm  = 1;
         if (err_sop_excess) seen_sopx = 1;
         if (err_overflow)   seen_ovf  = 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clr_in();
      in_data = '0; in_hdr = '0; in_prefix = '0; in_dvalid = '0; in_hvalid = '0;
      in_pvalid = '0; in_sop = '0; in_eop = '0; in_empty = '0; in_bar = '0;
      in_pfnum = '0; in_vfactive = '0; in_vfnum = '0;
      cor_d = '0; cor_h = '0; cor_p = '0;
   endtask

   task automatic set_seg(input int s, input bit sp, input bit ep, input logic [2:0] emp,
                          input logic [7:0] tag);
      in_dvalid[s] = 1'b1; in_sop[s] = sp; in_eop[s] = ep; in_hvalid[s] = sp;
      in_empty[s*3 +: 3] = emp;
      in_data[s*DW +: DW] = {NDW{24'h5A5A00, tag}};
      in_hdr[s*128 +: 128] = {4{24'hC3C300, tag}};
   endtask

   task automatic begin_test();
      @(negedge clk);
      cap_n = 0; seen_par = 0; seen_frm = 0; seen_sopx = 0; seen_ovf = 0;
      clr_in();
   endtask

   task automatic drain(input int n);
      repeat (n) @(negedge clk);
   endtask

   // {dvalid, sop, eop, expected beats[2:0], expected framing error}
   localparam logic [15:0] VEC [8] = '{16'h1112, 16'hF5A8, 16'h7776, 16'h6244,
                                       16'h3011, 16'h7345, 16'h8882, 16'hD186};

   initial begin
      #(4*20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      clr_in();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      drain(2);
      chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
      chk({err_parity, err_frame, err_sop_excess, err_overflow} == 4'b0, "R1",
          "error flags after reset", {err_parity, err_frame, err_sop_excess, err_overflow}, 0);

      for (int k = 0; k < 8; k++) begin
         logic [15:0] v;
         bit ord;
         v = VEC[k];
         begin_test();
         for (int s = 0; s < NSEG; s++)
            if (v[12+s]) set_seg(s, v[8+s], v[4+s], 3'd0, 8'(16*k + s));
         @(negedge clk);
         clr_in();
         drain(10);
         chk(cap_n == int'(v[3:1]), "R2", $sformatf("vector %0d beat count", k), cap_n, v[3:1]);
         chk(seen_frm == v[0], "R8", $sformatf("vector %0d framing flag", k), seen_frm, v[0]);
         chk(!seen_sopx, "R9", $sformatf("vector %0d no start excess", k), seen_sopx, 0);
         ord = 1;
         for (int i = 1; i < cap_n; i++) if (cap_tag[i] <= cap_tag[i-1]) ord = 0;
         chk(ord, "R2", $sformatf("vector %0d segment order", k), ord, 1);
      end

      // R3 / R4: packet open at segment 3 wraps to next cycle
      begin_test();
      set_seg(3, 1, 0, 3'd0, 8'h31);
      @(negedge clk);
      clr_in();
      set_seg(0, 0, 0, 3'd7, 8'h32);
      set_seg(1, 0, 1, 3'd5, 8'h33);
      @(negedge clk);
      clr_in();
      drain(8);
      chk(cap_n == 3 && !seen_frm, "R3", "wrap beats/no frame", {cap_n, seen_frm}, 3);
      chk({cap_sop[0], cap_sop[1], cap_sop[2]} == 3'b100, "R3", "sop marks",
          {cap_sop[0], cap_sop[1], cap_sop[2]}, 3'b100);
      chk({cap_eop[0], cap_eop[1], cap_eop[2]} == 3'b001, "R3", "eop marks",
          {cap_eop[0], cap_eop[1], cap_eop[2]}, 3'b001);
      chk(cap_dwen[1] == 8'hFF, "R4", "empty ignored off end", cap_dwen[1], 8'hFF);
      chk(cap_dwen[2] == 8'h07, "R4", "end dword enable", cap_dwen[2], 8'h07);

      // R5: routing, VF inactive then active
      for (int a = 0; a < 2; a++) begin
         begin_test();
         set_seg(2, 1, 1, 3'd0, 8'h51);
         in_hdr[2*128 +: 128] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
         in_bar[6 +: 3] = 3'd5; in_pfnum[6 +: 3] = 3'd3;
         in_vfactive[2] = a[0]; in_vfnum[22 +: 11] = 11'h155;
         @(negedge clk);
         clr_in();
         drain(6);
         chk(s_hdr == 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R5", "header", s_hdr,
             128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
         chk(s_bar == 3'd5 && s_pf == 3'd3, "R5", "bar/pf", {s_bar, s_pf}, {3'd5, 3'd3});
         chk(s_vfa == a[0] && s_vfn == (a[0] ? 11'h155 : 11'h0), "R5", "vf gating",
             {s_vfa, s_vfn}, {a[0], a[0] ? 11'h155 : 11'h0});
      end

      // R6: prefix present, zero prefix, unqualified prefix
      begin_test();
      set_seg(0, 1, 1, 3'd0, 8'h61); in_pvalid[0] = 1; in_prefix[0 +: 32] = 32'h6A00_0001;
      set_seg(1, 1, 1, 3'd0, 8'h62); in_pvalid[1] = 1; in_prefix[32 +: 32] = 32'h0;
      set_seg(2, 1, 1, 3'd0, 8'h63); in_pvalid[2] = 0; in_prefix[64 +: 32] = 32'h4B00_0000;
      @(negedge clk);
      clr_in();
      drain(8);
      chk(cap_n == 3 && cap_hp[0] && cap_pfx[0] == 32'h6A00_0001, "R6", "prefix present",
          cap_pfx[0], 32'h6A00_0001);
      chk(!cap_hp[1], "R6", "zero prefix absent", cap_hp[1], 0);
      chk(!cap_hp[2] && cap_pfx[2] == 0, "R6", "unqualified prefix", cap_pfx[2], 0);

      // R7: parity
      begin_test();
      set_seg(1, 1, 1, 3'd0, 8'h71); cor_d[1*NDW + 3] = 1'b1;
      @(negedge clk);
      clr_in();
      drain(4);
      chk(seen_par, "R7", "data parity mismatch", seen_par, 1);
      begin_test();
      set_seg(0, 1, 0, 3'd0, 8'h72);
      set_seg(1, 0, 1, 3'd0, 8'h73); cor_h[1*4 + 2] = 1'b1; cor_p[3] = 1'b1;
      @(negedge clk);
      clr_in();
      drain(6);
      chk(!seen_par && cap_n == 2, "R7", "unqualified parity ignored", seen_par, 0);

      // R9: four starts in one cycle
      begin_test();
      for (int s = 0; s < NSEG; s++) set_seg(s, 1, 1, 3'd0, 8'(8'h90 + s));
      @(negedge clk);
      clr_in();
      drain(8);
      chk(seen_sopx, "R9", "four starts flagged", seen_sopx, 1);

      // R10: overflow after three full cycles
      begin_test();
      for (int c = 0; c < 3; c++) begin
         for (int s = 0; s < NSEG; s++) set_seg(s, 1, 1, 3'd0, 8'(8'hA0 + 4*c + s));
         @(negedge clk);
         clr_in();
      end
      drain(16);
      chk(seen_ovf, "R10", "overflow flagged", seen_ovf, 1);
      chk(cap_n == 9, "R10", "beats kept", cap_n, 9);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule